// File: doc/BRIEF.md
# Serial Port Register Block

This block is the register face of a simple serial port. A processor reaches it over a small synchronous register bus. The bus uses a byte address, of which the word offset is taken from bits 11:2, 32-bit data, and one-cycle read and write strobes. The block holds:
- two control words that are used by the logic;
- two status words that software clears by writing 1 to a bit;
- a test/status word;
- several configuration words that only read back what was written.

Each direction of the serial path is reduced to a single character slot. A byte-wide receive input with valid/ready, plus a break strobe, loads the receive slot. Writes to the transmit-data offset come out on a byte-wide transmit output as a one-cycle pulse.

Reading the receive-data offset has side effects. It marks the slot empty and drops the receive-ready flags. Writing the second control word with its bit 0 low starts a soft reset of the register state. One registered level interrupt is formed from the receive-ready and transmit-ready status bits, gated by enables in the first control word.

Top module: `uart_regblock`

## Requirements
- R1: After hardware reset the block reads as follows: status-1 (0x25) = 0x6040, status-2 (0x26) = 0x4028, test (0x2D) = 0x0060, control-1 (0x20) = 0, control-2 (0x21) = 0x0001, control-3 (0x22) = 0x0700, baud count (0x2B) = 4, and receive data (0x00) = 0x4000. The interrupt is low, rxReady is high and txValid is low.
- R2: Writes to control-3 (0x22), FIFO control (0x24), baud modulator (0x2A) and one-millisecond (0x2C) keep data bits 15:0 and read back with upper bits zero. A write to the baud increment offset (0x29) loads the baud count read at 0x2B. Offsets 0x29 and 0x23, and any unmapped offset, read as zero.
- R3: When the receive input is taken (rxReady high with rxValid or rxBreak), the slot is loaded and three flags change: status-1 bit 9 is set, status-2 bit 0 is set, and test bit 5 (receive empty) is cleared. A plain character loads {8'h00, rxData}. A break loads 0x0800 and wins over a plain character offered in the same cycle.
- R4: rxReady equals the inverse of status-1 bit 9. A character or break offered while rxReady is low is ignored.
- R5: A read of offset 0x00 returns the slot in bits 15:0, with bit 15 also set when test bit 5 is clear. If the slot was full, the read clears status-1 bit 9 and status-2 bit 0 and sets test bit 5. A second read returns the value without bit 15.
- R6: A write to offset 0x10 while control-2 bit 2 is set pulses txValid for one cycle, starting the cycle after the write, with txData equal to the written bits 7:0. The same write clears status-1 bit 13 for exactly one cycle. With control-2 bit 2 clear, the write has no effect.
- R7: Writing status-1 clears only the written-1 bits that fall within mask 0x9DB0. Every other bit keeps its value.
- R8: Writing status-2 clears only the written-1 bits that fall within mask 0xBDD6. Every other bit keeps its value.
- R9: Writing control-2 with bit 0 = 0 has the following effects:
  - status, test, control-1, control-3, baud modulator, baud count and the receive slot return to their R1 values;
  - control-2 stores the written bits 15:0 with bit 0 forced to 1;
  - FIFO control and one-millisecond keep their values.
  A control-2 write with bit 0 = 1 just stores bits 15:0.
- R10: irqOut is registered one cycle behind the register state. It is high when status-1 bit 9 and control-1 bit 9 are both set. It is also high when status-1 bit 13, control-1 bit 13 and control-1 bit 6 are all set. It is low otherwise.
- R11: Writes to the test offset (0x2D) and to control-4 (0x23) leave every readable value unchanged.
- R12: busRdata presents the addressed value in the cycle after busRd. The value reflects the state before any side effect of that same read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address; bits 11:2 select the word |
| busWdata | input | 32 | Write data |
| busWr | input | 1 | Write strobe, one cycle |
| busRd | input | 1 | Read strobe, one cycle |
| busRdata | output | 32 | Registered read data |
| rxData | input | 8 | Received character |
| rxValid | input | 1 | Received character is offered |
| rxBreak | input | 1 | Break condition is offered |
| rxReady | output | 1 | Receive slot can take a character |
| txData | output | 8 | Transmitted character |
| txValid | output | 1 | One-cycle transmit pulse |
| irqOut | output | 1 | Level interrupt |

## Verification
The register map is tried with a fixed vector table of writes and reads. The table uses patterns with set upper bits, which show whether 16-bit truncation is applied. It uses all-ones writes to the status words, which show whether anything outside the clear masks is lost. It uses writes to the read-only and aliased offsets, which show whether an offset decodes to the wrong register.

The receive path is tried three ways: with a character, with a character offered while the slot is full, and with a break. The back-to-back data reads then separate the first read's ready flag and side effects from the second read's unchanged result.

The transmit and interrupt checks vary the enable bits one at a time. This shows which term of the interrupt each enable gates, and whether the one-cycle transmit-ready dip actually reaches the interrupt.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int REG_W  = 16;
  localparam int CHAR_W = 8;

  // Word offsets
  localparam int OFF_RXD   = 'h00;
  localparam int OFF_TXD   = 'h10;
  localparam int OFF_CTL1  = 'h20;
  localparam int OFF_CTL2  = 'h21;
  localparam int OFF_CTL3  = 'h22;
  localparam int OFF_CTL4  = 'h23;
  localparam int OFF_FCR   = 'h24;
  localparam int OFF_ST1   = 'h25;
  localparam int OFF_ST2   = 'h26;
  localparam int OFF_BINC  = 'h29;
  localparam int OFF_BMOD  = 'h2A;
  localparam int OFF_BCNT  = 'h2B;
  localparam int OFF_MS    = 'h2C;
  localparam int OFF_TEST  = 'h2D;

  // Bit positions
  localparam int B_RRDY    = 9;
  localparam int B_TRDY    = 13;
  localparam int B_RDR     = 0;
  localparam int B_RXEMPTY = 5;
  localparam int B_TXEN    = 2;
  localparam int B_SRST    = 0;
  localparam int B_TXIEN   = 6;
  localparam int B_CHRDY   = 15;

  // Clear masks and reset values
  localparam logic [REG_W-1:0] ST1_CLR_MASK = 16'h9DB0;
  localparam logic [REG_W-1:0] ST2_CLR_MASK = 16'hBDD6;
  localparam logic [REG_W-1:0] ST1_INIT     = 16'h6040;
  localparam logic [REG_W-1:0] ST2_INIT     = 16'h4028;
  localparam logic [REG_W-1:0] TEST_INIT    = 16'h0060;
  localparam logic [REG_W-1:0] CTL2_INIT    = 16'h0001;
  localparam logic [REG_W-1:0] CTL3_INIT    = 16'h0700;
  localparam logic [REG_W-1:0] BCNT_INIT    = 16'h0004;
  localparam logic [REG_W-1:0] RXHOLD_INIT  = 16'h4000;
  localparam logic [REG_W-1:0] BREAK_CODE   = 16'h0800;

  typedef struct packed {
    logic rxRead;
    logic txWrite;
    logic ctl1Wr;
    logic ctl2Wr;
    logic softRst;
    logic ctl3Wr;
    logic fcrWr;
    logic st1Clr;
    logic st2Clr;
    logic baudWr;
    logic bmodWr;
    logic msWr;
    logic rxTake;
    logic rxIsBreak;
  } regStrobes_t;
endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int OFF_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              wrSrstBit,
  input  logic              rxValid,
  input  logic              rxBreak,
  input  logic              rxFull,
  output logic [OFF_W-1:0]  rdOff,
  output regStrobes_t       stb
);
  logic [OFF_W-1:0] off;

  function automatic logic hit(input logic [OFF_W-1:0] o, input int target);
    return o == OFF_W'(target);
  endfunction

  assign off   = busAddr[ADDR_W-1:2];
  assign rdOff = off;

  always_comb begin
    stb           = '0;
    stb.rxRead    = busRd && hit(off, OFF_RXD);
    stb.txWrite   = busWr && hit(off, OFF_TXD);
    stb.ctl1Wr    = busWr && hit(off, OFF_CTL1);
    stb.ctl2Wr    = busWr && hit(off, OFF_CTL2) && wrSrstBit;
    stb.softRst   = busWr && hit(off, OFF_CTL2) && !wrSrstBit;
    stb.ctl3Wr    = busWr && hit(off, OFF_CTL3);
    stb.fcrWr     = busWr && hit(off, OFF_FCR);
    stb.st1Clr    = busWr && hit(off, OFF_ST1);
    stb.st2Clr    = busWr && hit(off, OFF_ST2);
    stb.baudWr    = busWr && hit(off, OFF_BINC);
    stb.bmodWr    = busWr && hit(off, OFF_BMOD);
    stb.msWr      = busWr && hit(off, OFF_MS);
    stb.rxTake    = !rxFull && (rxValid || rxBreak);
    stb.rxIsBreak = rxBreak;
  end
endmodule

// File: rtl/uart_reg_data.sv
module uart_reg_data
  import uart_reg_pkg::*;
#(
  parameter int OFF_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        stb,
  input  logic [REG_W-1:0]   wdata,
  input  logic               rdEn,
  input  logic [OFF_W-1:0]   rdOff,
  input  logic [CHAR_W-1:0]  rxChar,
  output logic [DATA_W-1:0]  rdata,
  output logic [CHAR_W-1:0]  txData,
  output logic               txValid,
  output logic               irq,
  output logic [REG_W-1:0]   st1Val,
  output logic [REG_W-1:0]   st2Val,
  output logic [REG_W-1:0]   ctl1Val,
  output logic [REG_W-1:0]   ctl2Val
);
  logic [REG_W-1:0] st1Q, st2Q, testQ, ctl1Q, ctl2Q, ctl3Q;
  logic [REG_W-1:0] fcrQ, bmodQ, bcntQ, msQ, rxHoldQ;
  logic [REG_W-1:0] st1D, st2D, testD, rxHoldD;
  logic             trdyRestoreQ;
  logic             txSend, rxHadChar, irqD;
  logic [REG_W-1:0] rdMux, rxView;

  assign txSend    = stb.txWrite && ctl2Q[B_TXEN];
  assign rxHadChar = !testQ[B_RXEMPTY];

  // Next-state of the status words and receive slot
  always_comb begin
    st1D    = st1Q;
    st2D    = st2Q;
    testD   = testQ;
    rxHoldD = rxHoldQ;
    if (trdyRestoreQ) st1D[B_TRDY] = 1'b1;
    if (stb.st1Clr) st1D = st1D & ~(wdata & ST1_CLR_MASK);
    if (stb.st2Clr) st2D = st2D & ~(wdata & ST2_CLR_MASK);
    if (txSend) st1D[B_TRDY] = 1'b0;
    if (stb.rxRead && rxHadChar) begin
      st1D[B_RRDY]     = 1'b0;
      st2D[B_RDR]      = 1'b0;
      testD[B_RXEMPTY] = 1'b1;
    end
    if (stb.rxTake) begin
      st1D[B_RRDY]     = 1'b1;
      st2D[B_RDR]      = 1'b1;
      testD[B_RXEMPTY] = 1'b0;
      rxHoldD          = stb.rxIsBreak ? BREAK_CODE : REG_W'(rxChar);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.softRst) begin
      st1Q         <= ST1_INIT;
      st2Q         <= ST2_INIT;
      testQ        <= TEST_INIT;
      ctl1Q        <= '0;
      ctl2Q        <= rstN ? (wdata | CTL2_INIT) : CTL2_INIT;
      ctl3Q        <= CTL3_INIT;
      bmodQ        <= '0;
      bcntQ        <= BCNT_INIT;
      rxHoldQ      <= RXHOLD_INIT;
      trdyRestoreQ <= 1'b0;
    end else begin
      st1Q         <= st1D;
      st2Q         <= st2D;
      testQ        <= testD;
      rxHoldQ      <= rxHoldD;
      trdyRestoreQ <= txSend;
      if (stb.ctl1Wr) ctl1Q <= wdata;
      if (stb.ctl2Wr) ctl2Q <= wdata;
      if (stb.ctl3Wr) ctl3Q <= wdata;
      if (stb.bmodWr) bmodQ <= wdata;
      if (stb.baudWr) bcntQ <= wdata;
    end
  end

  // Registers untouched by soft reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fcrQ <= '0;
      msQ  <= '0;
    end else begin
      if (stb.fcrWr) fcrQ <= wdata;
      if (stb.msWr)  msQ  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else begin
      txValid <= txSend;
      if (txSend) txData <= wdata[CHAR_W-1:0];
    end
  end

  assign irqD = (st1Q[B_RRDY] && ctl1Q[B_RRDY]) ||
                (st1Q[B_TRDY] && ctl1Q[B_TRDY] && ctl1Q[B_TXIEN]);

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= irqD;
  end

  always_comb begin
    rxView = rxHoldQ;
    if (rxHadChar) rxView[B_CHRDY] = 1'b1;
    unique case (int'(rdOff))
      OFF_RXD:  rdMux = rxView;
      OFF_CTL1: rdMux = ctl1Q;
      OFF_CTL2: rdMux = ctl2Q;
      OFF_CTL3: rdMux = ctl3Q;
      OFF_FCR:  rdMux = fcrQ;
      OFF_ST1:  rdMux = st1Q;
      OFF_ST2:  rdMux = st2Q;
      OFF_BMOD: rdMux = bmodQ;
      OFF_BCNT: rdMux = bcntQ;
      OFF_MS:   rdMux = msQ;
      OFF_TEST: rdMux = testQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdata <= '0;
    else if (rdEn) rdata <= DATA_W'(rdMux);
  end

  assign st1Val  = st1Q;
  assign st2Val  = st2Q;
  assign ctl1Val = ctl1Q;
  assign ctl2Val = ctl2Q;
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxValid,
  input  logic              rxBreak,
  output logic              rxReady,
  output logic [CHAR_W-1:0] txData,
  output logic              txValid,
  output logic              irqOut
);
  localparam int OFF_W = ADDR_W - 2;

  regStrobes_t      stb;
  logic [OFF_W-1:0] rdOff;
  logic [REG_W-1:0] st1Val, st2Val, ctl1Val, ctl2Val;

  uart_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .wrSrstBit (busWdata[B_SRST]),
    .rxValid   (rxValid),
    .rxBreak   (rxBreak),
    .rxFull    (st1Val[B_RRDY]),
    .rdOff     (rdOff),
    .stb       (stb)
  );

  uart_reg_data #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wdata   (busWdata[REG_W-1:0]),
    .rdEn    (busRd),
    .rdOff   (rdOff),
    .rxChar  (rxData),
    .rdata   (busRdata),
    .txData  (txData),
    .txValid (txValid),
    .irq     (irqOut),
    .st1Val  (st1Val),
    .st2Val  (st2Val),
    .ctl1Val (ctl1Val),
    .ctl2Val (ctl2Val)
  );

  assign rxReady = !st1Val[B_RRDY];
endmodule

// File: rtl/uart_reg_checker.sv
module uart_reg_checker
  import uart_reg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic             busRd,
  input logic [9:0]       busOff,
  input logic             rxValid,
  input logic             rxBreak,
  input logic             rxReady,
  input logic             txValid,
  input logic             irqOut,
  input logic [REG_W-1:0] st1,
  input logic [REG_W-1:0] st2,
  input logic [REG_W-1:0] ctl1,
  input logic [REG_W-1:0] ctl2
);
  assert_rx_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxReady && (rxValid || rxBreak) |=> st1[B_RRDY] && st2[B_RDR] && !rxReady);

  assert_full_ignores_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rxReady && rxValid && !busRd |=> !rxReady && st2[B_RDR]);

  assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busOff == 10'(OFF_TXD) && ctl2[B_TXEN] |=> txValid && !st1[B_TRDY]);

  assert_tx_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> !txValid);

  assert_st1_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busOff == 10'(OFF_ST1) && !rxValid && !rxBreak |=> st1[B_RRDY] == $past(st1[B_RRDY]));

  assert_srst_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl2[B_SRST]);

  assert_irq_rx_R10: assert property (@(posedge clk) disable iff (!rstN)
    st1[B_RRDY] && ctl1[B_RRDY] |=> irqOut);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(st1[B_RRDY] && ctl1[B_RRDY]) && !(st1[B_TRDY] && ctl1[B_TRDY] && ctl1[B_TXIEN]) |=> !irqOut);
endmodule

bind uart_regblock uart_reg_checker u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busWr   (busWr),
  .busRd   (busRd),
  .busOff  (busAddr[11:2]),
  .rxValid (rxValid),
  .rxBreak (rxBreak),
  .rxReady (rxReady),
  .txValid (txValid),
  .irqOut  (irqOut),
  .st1     (st1Val),
  .st2     (st2Val),
  .ctl1    (ctl1Val),
  .ctl2    (ctl2Val)
);

// File: tb/uart_regblock_bench.sv
module uart_regblock_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic [7:0]  rxData = '0;
  logic        rxValid = 1'b0;
  logic        rxBreak = 1'b0;
  logic        rxReady;
  logic [7:0]  txData;
  logic        txValid;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  uart_regblock u_uart_regblock (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
    .rxData(rxData), .rxValid(rxValid), .rxBreak(rxBreak), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .irqOut(irqOut)
  );

  // Entry: {isWrite, offset, data, expected read}
  localparam int NV = 28;
  localparam logic [58:0] VEC [NV] = '{
    {1'b0, 10'h020, 32'h0, 16'h0000},   // R1
    {1'b0, 10'h021, 32'h0, 16'h0001},   // R1
    {1'b0, 10'h022, 32'h0, 16'h0700},   // R1
    {1'b0, 10'h025, 32'h0, 16'h6040},   // R1
    {1'b0, 10'h026, 32'h0, 16'h4028},   // R1
    {1'b0, 10'h02D, 32'h0, 16'h0060},   // R1
    {1'b0, 10'h02B, 32'h0, 16'h0004},   // R1
    {1'b0, 10'h000, 32'h0, 16'h4000},   // R1 R5
    {1'b1, 10'h022, 32'hABCD1234, 16'h0},
    {1'b0, 10'h022, 32'h0, 16'h1234},   // R2
    {1'b1, 10'h024, 32'hFFFF0081, 16'h0},
    {1'b0, 10'h024, 32'h0, 16'h0081},   // R2
    {1'b1, 10'h02A, 32'h00015555, 16'h0},
    {1'b0, 10'h02A, 32'h0, 16'h5555},   // R2
    {1'b1, 10'h02C, 32'h12345678, 16'h0},
    {1'b0, 10'h02C, 32'h0, 16'h5678},   // R2
    {1'b1, 10'h029, 32'h0000BEEF, 16'h0},
    {1'b0, 10'h02B, 32'h0, 16'hBEEF},   // R2
    {1'b0, 10'h029, 32'h0, 16'h0000},   // R2
    {1'b1, 10'h023, 32'h0000FFFF, 16'h0},
    {1'b0, 10'h023, 32'h0, 16'h0000},   // R11
    {1'b1, 10'h02D, 32'h0000FFFF, 16'h0},
    {1'b0, 10'h02D, 32'h0, 16'h0060},   // R11
    {1'b0, 10'h3FF, 32'h0, 16'h0000},   // R2
    {1'b1, 10'h025, 32'hFFFFFFFF, 16'h0},
    {1'b0, 10'h025, 32'h0, 16'h6040},   // R7
    {1'b1, 10'h026, 32'hFFFFFFFF, 16'h0},
    {1'b0, 10'h026, 32'h0, 16'h4028}    // R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [9:0] off, input logic [31:0] data);
    @(negedge clk);
    busAddr = {off, 2'b00};
    busWdata = data;
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [9:0] off, output logic [31:0] data);
    @(negedge clk);
    busAddr = {off, 2'b00};
    busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    data = busRdata;
  endtask

  task automatic readCheck(input string req, input logic [9:0] off, input logic [31:0] exp);
    logic [31:0] v;
    busRead(off, v);
    check(req, v, exp);
  endtask

  task automatic pushRx(input logic [7:0] ch, input logic brk);
    @(negedge clk);
    rxData = ch;
    rxValid = !brk;
    rxBreak = brk;
    @(negedge clk);
    rxValid = 1'b0;
    rxBreak = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 port reset state
    check("R1 irq", 32'(irqOut), 32'd0);
    check("R1 rxReady", 32'(rxReady), 32'd1);
    check("R1 txValid", 32'(txValid), 32'd0);

    // Vector table; R12 latency is exercised by every read
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][58]) busWrite(VEC[i][57:48], VEC[i][47:16]);
      else readCheck("R2/R12 table", VEC[i][57:48], {16'h0, VEC[i][15:0]});
    end

    // R3 R4 R5 receive path
    pushRx(8'h5A, 1'b0);
    check("R4 rxReady low when full", 32'(rxReady), 32'd0);
    readCheck("R3 st1", 10'h025, 32'h6240);
    readCheck("R3 st2", 10'h026, 32'h4029);
    readCheck("R3 test", 10'h02D, 32'h0040);
    pushRx(8'h77, 1'b0);
    readCheck("R5 first read", 10'h000, 32'h805A);
    readCheck("R5 st1 after read", 10'h025, 32'h6040);
    readCheck("R5 test after read", 10'h02D, 32'h0060);
    readCheck("R5 second read", 10'h000, 32'h005A);
    check("R4 rxReady back", 32'(rxReady), 32'd1);
    pushRx(8'h33, 1'b1);
    readCheck("R3 break", 10'h000, 32'h8800);

    // R10 interrupt gating
    busWrite(10'h020, 32'h0200);
    @(negedge clk);
    check("R10 idle with rx enable", 32'(irqOut), 32'd0);
    pushRx(8'h11, 1'b0);
    @(negedge clk);
    check("R10 rx irq", 32'(irqOut), 32'd1);
    readCheck("R10 drain", 10'h000, 32'h8011);
    @(negedge clk);
    check("R10 irq after drain", 32'(irqOut), 32'd0);
    busWrite(10'h020, 32'h2000);
    @(negedge clk);
    check("R10 tx needs bit6", 32'(irqOut), 32'd0);
    busWrite(10'h020, 32'h2040);
    @(negedge clk);
    check("R10 tx irq", 32'(irqOut), 32'd1);

    // R6 transmit
    busWrite(10'h010, 32'h000001A5);
    check("R6 no tx without enable", 32'(txValid), 32'd0);
    @(negedge clk);
    check("R6 irq steady without enable", 32'(irqOut), 32'd1);
    busWrite(10'h021, 32'h0005);
    busWrite(10'h010, 32'h000001A5);
    check("R6 txValid", 32'(txValid), 32'd1);
    check("R6 txData", 32'(txData), 32'h00A5);
    @(negedge clk);
    check("R6 single pulse", 32'(txValid), 32'd0);
    check("R6 irq dip", 32'(irqOut), 32'd0);
    @(negedge clk);
    check("R6 irq restored", 32'(irqOut), 32'd1);

    // R9 soft reset
    busWrite(10'h022, 32'h1111);
    pushRx(8'h42, 1'b0);
    busWrite(10'h021, 32'h0004);
    readCheck("R9 ctl2 forced", 10'h021, 32'h0005);
    readCheck("R9 ctl1", 10'h020, 32'h0000);
    readCheck("R9 ctl3", 10'h022, 32'h0700);
    readCheck("R9 st1", 10'h025, 32'h6040);
    readCheck("R9 rx slot", 10'h000, 32'h4000);
    readCheck("R9 baud count", 10'h02B, 32'h0004);
    readCheck("R9 fcr kept", 10'h024, 32'h0081);
    readCheck("R9 ms kept", 10'h02C, 32'h5678);
    check("R9 irq", 32'(irqOut), 32'd0);
    busWrite(10'h021, 32'h0003);
    readCheck("R9 plain ctl2 write", 10'h021, 32'h0003);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule